// File: doc/BRIEF.md
# Checkpoint Register Recovery Sequencer

This block keeps the committed architected state of a processor in a bank of checkpoint registers, each word stored with single-error-correct, double-error-detect check bits. Two duplicated execution units present their results on two result ports. A result enters the checkpoint only when both copies agree in valid, register index and data. Any disagreement, or the external error flag, stops checkpoint updates and starts a fixed recovery script.

The script drains stores that were already checkpointed, resets the local arrays and the branch target buffer, and scrubs every checkpoint register in index order. Each scrubbed word is corrected, written back and broadcast on a shadow-copy write port. A second pass then verifies every register. After that, the block raises a serialization interrupt to restart fetch, waits for the first instruction to complete cleanly, and finally raises an asynchronous logging interrupt. Each wait on another unit is a request/acknowledge handshake guarded by a timeout. Four distinct failures lead to a sticky check-stop: an uncorrectable word in the scrub pass, any error in the verify pass, a repeat error before the first completion, and a handshake timeout.

State names used below: RUN, FREEZE, DRAIN, ARRAY_RST, SCRUB, VERIFY, RESTART, CONFIRM, LOG, CHKSTOP. Transitions: RUN to FREEZE on error; FREEZE to DRAIN; DRAIN to ARRAY_RST on ack; ARRAY_RST to SCRUB on ack; SCRUB to VERIFY after the last register; VERIFY to RESTART after the last register; RESTART to CONFIRM on ack; CONFIRM to LOG on a clean completion; LOG to RUN on ack and to FREEZE on a new error. Any timeout, scrub uncorrectable, verify error or CONFIRM error goes to CHKSTOP.

Top module: `ckpt_recovery_seq`

## Requirements
- R1: After reset the block is in RUN: all requests, `shd_we`, `recovering` and `chkstop` are 0, `stop_cause` is 0, and every checkpoint register holds data 0 with valid check bits.
- R2: A cycle with either result valid is an event. It matches only if both valids are 1 and both index and data are equal. In RUN, a non-matching event moves the block to FREEZE, so `recovering` is 1 from the next cycle.
- R3: A matching event in RUN, CONFIRM or LOG (with `err_flag` low) writes the data into the indexed register with freshly generated check bits. The value written is the value later broadcast for that register.
- R4: From the cycle an error is detected until CONFIRM, no result updates the checkpoint.
- R5: `drain_req` is held in DRAIN until `drain_ack`, then `arr_rst_req` is held in ARRAY_RST until `arr_rst_ack`. At most one request output is high in any cycle.
- R6: SCRUB visits registers 0 to NREG-1, one per cycle. For a correctable word it drives `shd_we` with `shd_idx` equal to the index and `shd_data` equal to the corrected data, and writes the corrected word back. The stored word is 39 bits, with data at [31:0] and check bits at [38:32]; any single flipped bit is corrected.
- R7: A word with two flipped bits in SCRUB is not broadcast and causes CHKSTOP with `stop_cause` 1.
- R8: In VERIFY any correctable or uncorrectable error causes CHKSTOP with `stop_cause` 2.
- R9: RESTART holds `restart_req` until `restart_ack`. In CONFIRM, a non-matching event or `err_flag` causes CHKSTOP with `stop_cause` 3, and a matching event moves to LOG.
- R10: LOG holds `log_req` until `log_ack`, then returns to RUN. Matching results are committed during LOG.
- R11: In DRAIN, ARRAY_RST, RESTART, CONFIRM and LOG, staying TIMEOUT cycles without progress causes CHKSTOP with `stop_cause` 4.
- R12: CHKSTOP is left only by reset. In it, `chkstop` is 1, `stop_cause` is non-zero, and no request or shadow write is issued.
- R13: `err_flag` high in RUN starts recovery exactly as a mismatch does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_a_valid | input | 1 | Result valid, unit A |
| res_a_idx | input | IW | Destination register, unit A |
| res_a_data | input | DW | Result data, unit A |
| res_b_valid | input | 1 | Result valid, unit B |
| res_b_idx | input | IW | Destination register, unit B |
| res_b_data | input | DW | Result data, unit B |
| err_flag | input | 1 | Error reported by another unit |
| drain_req | output | 1 | Forward checkpointed stores |
| drain_ack | input | 1 | Drain done |
| arr_rst_req | output | 1 | Reset local arrays and branch target buffer |
| arr_rst_ack | input | 1 | Array reset done |
| restart_req | output | 1 | Serialization interrupt, restart fetch |
| restart_ack | input | 1 | Restart accepted |
| log_req | output | 1 | Asynchronous logging interrupt |
| log_ack | input | 1 | Logging accepted |
| shd_we | output | 1 | Shadow copy write enable |
| shd_idx | output | IW | Shadow copy register index |
| shd_data | output | DW | Corrected shadow copy data |
| flt_en | input | 1 | Error injection: hold a read-path flip mask on one register |
| flt_store | input | 1 | Error injection: flip stored bits of one register once |
| flt_idx | input | IW | Error injection register |
| flt_mask | input | CW | Error injection bit mask over the stored word |
| recovering | output | 1 | Recovery script in progress |
| chkstop | output | 1 | Sticky check-stop |
| stop_cause | output | 3 | 0 none, 1 uncorrectable, 2 persistent, 3 repeat, 4 timeout |

## Verification
The bench builds the block with NREG = 8 and TIMEOUT = 32, keeping DW = 32. A full scrub and verify pass then takes 16 cycles, and a handshake timeout fires within a few dozen cycles. This brings all four check-stop exits, repeated recovery, and the write-back of corrected words into a short run. The 32-bit data width keeps the 39-bit stored word and its correction behaviour the same as in the default build.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;

    typedef enum logic [3:0] {
        ST_RUN,
        ST_FREEZE,
        ST_DRAIN,
        ST_ARRAY_RST,
        ST_SCRUB,
        ST_VERIFY,
        ST_RESTART,
        ST_CONFIRM,
        ST_LOG,
        ST_CHKSTOP
    } rec_state_e;

    typedef enum logic [2:0] {
        STOP_NONE    = 3'd0,
        STOP_UNCORR  = 3'd1,
        STOP_PERSIST = 3'd2,
        STOP_REPEAT  = 3'd3,
        STOP_TIMEOUT = 3'd4
    } stop_cause_e;

    // Number of Hamming check bits for a data width (overall parity excluded).
    function automatic int hamming_bits(input int dw);
        int p;
        p = 1;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    // Codeword position of data bit d: the d-th position that is not a power of two.
    function automatic int data_pos(input int d);
        int cnt;
        int pos;
        cnt = 0;
        pos = 0;
        for (int q = 3; q <= 2 * d + 8; q++) begin
            if (pos == 0 && (q & (q - 1)) != 0) begin
                if (cnt == d) pos = q;
                cnt++;
            end
        end
        return pos;
    endfunction

endpackage

// File: rtl/ckpt_secded_enc.sv
module ckpt_secded_enc
    import ckpt_pkg::*;
#(
    parameter int DW = 32,
    parameter int PW = hamming_bits(DW)
) (
    input  logic [DW-1:0] data,
    output logic [PW:0]   chk
);

    logic [PW-1:0] ham;

    always_comb begin
        logic [31:0] pos;
        ham = '0;
        for (int d = 0; d < DW; d++) begin
            pos = 32'(data_pos(d));
            for (int b = 0; b < PW; b++) begin
                if (pos[b]) ham[b] = ham[b] ^ data[d];
            end
        end
        chk = {(^data) ^ (^ham), ham};
    end

endmodule

// File: rtl/ckpt_secded_dec.sv
module ckpt_secded_dec
    import ckpt_pkg::*;
#(
    parameter int DW = 32,
    parameter int PW = hamming_bits(DW)
) (
    input  logic [DW-1:0] data,
    input  logic [PW:0]   chk,
    output logic [DW-1:0] cdata,
    output logic          err_corr,
    output logic          err_unc
);

    logic [PW-1:0] ham;
    logic [PW-1:0] syn;
    logic          odd;

    always_comb begin
        logic [31:0] pos;
        ham = '0;
        for (int d = 0; d < DW; d++) begin
            pos = 32'(data_pos(d));
            for (int b = 0; b < PW; b++) begin
                if (pos[b]) ham[b] = ham[b] ^ data[d];
            end
        end
        syn = ham ^ chk[PW-1:0];
        odd = (^data) ^ (^chk);
        cdata = data;
        for (int d = 0; d < DW; d++) begin
            if (odd && syn == PW'(data_pos(d))) cdata[d] = ~data[d];
        end
        err_corr = odd;
        err_unc  = !odd && (syn != '0);
    end

endmodule

// File: rtl/ckpt_regfile.sv
module ckpt_regfile #(
    parameter int NREG = 16,
    parameter int CW   = 39,
    parameter int IW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [CW-1:0] wword,
    input  logic          flt_en,
    input  logic          flt_store,
    input  logic [IW-1:0] flt_idx,
    input  logic [CW-1:0] flt_mask,
    input  logic [IW-1:0] ridx,
    output logic [CW-1:0] rword
);

    logic [CW-1:0] mem_q [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[widx] <= wword;
        end else if (flt_store) begin
            mem_q[flt_idx] <= mem_q[flt_idx] ^ flt_mask;
        end
    end

    // A held injection models a solid fault on the read path.
    assign rword = mem_q[ridx] ^ ((flt_en && flt_idx == ridx) ? flt_mask : '0);

endmodule

// File: rtl/ckpt_recovery_seq.sv
module ckpt_recovery_seq
    import ckpt_pkg::*;
#(
    parameter int NREG    = 16,
    parameter int DW      = 32,
    parameter int TIMEOUT = 256,
    localparam int IW     = $clog2(NREG),
    localparam int PW     = hamming_bits(DW),
    localparam int CW     = DW + PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          res_a_valid,
    input  logic [IW-1:0] res_a_idx,
    input  logic [DW-1:0] res_a_data,
    input  logic          res_b_valid,
    input  logic [IW-1:0] res_b_idx,
    input  logic [DW-1:0] res_b_data,
    input  logic          err_flag,
    output logic          drain_req,
    input  logic          drain_ack,
    output logic          arr_rst_req,
    input  logic          arr_rst_ack,
    output logic          restart_req,
    input  logic          restart_ack,
    output logic          log_req,
    input  logic          log_ack,
    output logic          shd_we,
    output logic [IW-1:0] shd_idx,
    output logic [DW-1:0] shd_data,
    input  logic          flt_en,
    input  logic          flt_store,
    input  logic [IW-1:0] flt_idx,
    input  logic [CW-1:0] flt_mask,
    output logic          recovering,
    output logic          chkstop,
    output logic [2:0]    stop_cause
);

    localparam int TW = $clog2(TIMEOUT + 1);

    rec_state_e    state_q, state_d;
    stop_cause_e   cause_q, cause_d;
    logic [IW-1:0] scan_q;
    logic [TW-1:0] wait_q;

    logic          event_any, event_match, event_bad;
    logic          waiting, timed_out, scan_last;
    logic          commit, scrub_we;
    logic [CW-1:0] rd_word, wr_word;
    logic [DW-1:0] dec_data, enc_in;
    logic          dec_corr, dec_unc;
    logic [PW:0]   enc_chk;
    logic          rf_we;
    logic [IW-1:0] rf_widx;

    // Cross-compare of the duplicated units
    assign event_any   = res_a_valid | res_b_valid;
    assign event_match = res_a_valid && res_b_valid &&
                         (res_a_idx == res_b_idx) && (res_a_data == res_b_data);
    assign event_bad   = (event_any && !event_match) || err_flag;

    assign waiting   = (state_q == ST_DRAIN) || (state_q == ST_ARRAY_RST) ||
                       (state_q == ST_RESTART) || (state_q == ST_CONFIRM) ||
                       (state_q == ST_LOG);
    assign timed_out = waiting && (wait_q == TW'(TIMEOUT - 1));
    assign scan_last = (scan_q == IW'(NREG - 1));

    // Storage and ECC
    ckpt_regfile #(.NREG(NREG), .CW(CW), .IW(IW)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (rf_we),
        .widx     (rf_widx),
        .wword    (wr_word),
        .flt_en   (flt_en),
        .flt_store(flt_store),
        .flt_idx  (flt_idx),
        .flt_mask (flt_mask),
        .ridx     (scan_q),
        .rword    (rd_word)
    );

    ckpt_secded_dec #(.DW(DW), .PW(PW)) u_dec (
        .data    (rd_word[DW-1:0]),
        .chk     (rd_word[CW-1:DW]),
        .cdata   (dec_data),
        .err_corr(dec_corr),
        .err_unc (dec_unc)
    );

    assign enc_in = (state_q == ST_SCRUB) ? dec_data : res_a_data;

    ckpt_secded_enc #(.DW(DW), .PW(PW)) u_enc (
        .data(enc_in),
        .chk (enc_chk)
    );

    assign wr_word = {enc_chk, enc_in};
    assign rf_we   = commit | scrub_we;
    assign rf_widx = scrub_we ? scan_q : res_a_idx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cause_q <= STOP_NONE;
            scan_q  <= '0;
            wait_q  <= '0;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
            if ((state_q == ST_SCRUB || state_q == ST_VERIFY) && state_d == state_q)
                scan_q <= scan_q + 1'b1;
            else
                scan_q <= '0;
            if (waiting && state_d == state_q)
                wait_q <= wait_q + 1'b1;
            else
                wait_q <= '0;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        unique case (state_q)
            ST_RUN: begin
                if (event_bad) state_d = ST_FREEZE;
            end
            ST_FREEZE: begin
                state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (drain_ack) begin
                    state_d = ST_ARRAY_RST;
                end else if (timed_out) begin
                    state_d = ST_CHKSTOP;
                    cause_d = STOP_TIMEOUT;
                end
            end
            ST_ARRAY_RST: begin
                if (arr_rst_ack) begin
                    state_d = ST_SCRUB;
                end else if (timed_out) begin
                    state_d = ST_CHKSTOP;
                    cause_d = STOP_TIMEOUT;
                end
            end
            ST_SCRUB: begin
                if (dec_unc) begin
                    state_d = ST_CHKSTOP;
                    cause_d = STOP_UNCORR;
                end else if (scan_last) begin
                    state_d = ST_VERIFY;
                end
            end
            ST_VERIFY: begin
                if (dec_corr || dec_unc) begin
                    state_d = ST_CHKSTOP;
                    cause_d = STOP_PERSIST;
                end else if (scan_last) begin
                    state_d = ST_RESTART;
                end
            end
            ST_RESTART: begin
                if (restart_ack) begin
                    state_d = ST_CONFIRM;
                end else if (timed_out) begin
                    state_d = ST_CHKSTOP;
                    cause_d = STOP_TIMEOUT;
                end
            end
            ST_CONFIRM: begin
                if (event_bad) begin
                    state_d = ST_CHKSTOP;
                    cause_d = STOP_REPEAT;
                end else if (event_match) begin
                    state_d = ST_LOG;
                end else if (timed_out) begin
                    state_d = ST_CHKSTOP;
                    cause_d = STOP_TIMEOUT;
                end
            end
            ST_LOG: begin
                if (event_bad) begin
                    state_d = ST_FREEZE;
                end else if (log_ack) begin
                    state_d = ST_RUN;
                end else if (timed_out) begin
                    state_d = ST_CHKSTOP;
                    cause_d = STOP_TIMEOUT;
                end
            end
            ST_CHKSTOP: begin
                state_d = ST_CHKSTOP;
            end
            default: begin
                state_d = ST_CHKSTOP;
                cause_d = STOP_PERSIST;
            end
        endcase
    end

    // Outputs
    always_comb begin
        drain_req   = 1'b0;
        arr_rst_req = 1'b0;
        restart_req = 1'b0;
        log_req     = 1'b0;
        commit      = 1'b0;
        scrub_we    = 1'b0;
        recovering  = 1'b1;
        chkstop     = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                recovering = 1'b0;
                commit     = event_match && !err_flag;
            end
            ST_FREEZE:    ;
            ST_DRAIN:     drain_req   = 1'b1;
            ST_ARRAY_RST: arr_rst_req = 1'b1;
            ST_SCRUB:     scrub_we    = !dec_unc;
            ST_VERIFY:    ;
            ST_RESTART:   restart_req = 1'b1;
            ST_CONFIRM:   commit      = event_match && !err_flag;
            ST_LOG: begin
                log_req = 1'b1;
                commit  = event_match && !err_flag;
            end
            ST_CHKSTOP: begin
                recovering = 1'b0;
                chkstop    = 1'b1;
            end
            default: begin
                recovering = 1'b0;
                chkstop    = 1'b1;
            end
        endcase
    end

    assign shd_we     = scrub_we;
    assign shd_idx    = scan_q;
    assign shd_data   = dec_data;
    assign stop_cause = cause_q;

endmodule

// File: rtl/ckpt_recovery_sva.sv
module ckpt_recovery_sva #(
    parameter int IW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          err_flag,
    input logic          drain_req,
    input logic          arr_rst_req,
    input logic          restart_req,
    input logic          log_req,
    input logic          shd_we,
    input logic [IW-1:0] shd_idx,
    input logic          recovering,
    input logic          chkstop,
    input logic [2:0]    stop_cause
);

    a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        chkstop |=> chkstop);

    a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        chkstop |-> !(drain_req || arr_rst_req || restart_req || log_req || shd_we));

    a_r12_cause: assert property (@(posedge clk) disable iff (!rst_n)
        chkstop |-> stop_cause != 3'd0);

    a_r13_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!recovering && !chkstop && err_flag) |=> recovering);

    a_r5_order: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_rst_req) |-> $past(drain_req));

    a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drain_req, arr_rst_req, restart_req, log_req}));

    a_r6_scan_order: assert property (@(posedge clk) disable iff (!rst_n)
        (shd_we && $past(shd_we)) |-> shd_idx == IW'($past(shd_idx) + 1'b1));

endmodule

bind ckpt_recovery_seq ckpt_recovery_sva #(.IW(IW)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_flag   (err_flag),
    .drain_req  (drain_req),
    .arr_rst_req(arr_rst_req),
    .restart_req(restart_req),
    .log_req    (log_req),
    .shd_we     (shd_we),
    .shd_idx    (shd_idx),
    .recovering (recovering),
    .chkstop    (chkstop),
    .stop_cause (stop_cause)
);

// File: tb/tb_ckpt_recovery_seq.sv
`timescale 1ns/1ps
module tb_ckpt_recovery_seq;

    localparam int NREG = 8;
    localparam int TO   = 32;
    localparam int IW   = 3;
    localparam int CW   = 39;

    logic clk = 0;
    logic rst_n = 0;
    logic a_v = 0, b_v = 0, err = 0;
    logic [IW-1:0] a_i = 0, b_i = 0;
    logic [31:0] a_d = 0, b_d = 0;
    logic drain_req, arr_rst_req, restart_req, log_req;
    logic drain_ack = 0, arr_rst_ack = 0, restart_ack = 0, log_ack = 0;
    logic shd_we;
    logic [IW-1:0] shd_idx;
    logic [31:0] shd_data;
    logic flt_en = 0, flt_store = 0;
    logic [IW-1:0] flt_idx = 0;
    logic [CW-1:0] flt_mask = 0;
    logic recovering, chkstop;
    logic [2:0] stop_cause;

    int checks = 0, fails = 0, cycles = 0;
    int drain_dly = 3, arr_dly = 0, rst_dly = 2, log_dly = 4;
    int c_dr = 0, c_ar = 0, c_rs = 0, c_lg = 0;
    logic [31:0] seen5 = 0;

    always #5 clk = ~clk;

    ckpt_recovery_seq #(.NREG(NREG), .DW(32), .TIMEOUT(TO)) dut (
        .clk(clk), .rst_n(rst_n),
        .res_a_valid(a_v), .res_a_idx(a_i), .res_a_data(a_d),
        .res_b_valid(b_v), .res_b_idx(b_i), .res_b_data(b_d),
        .err_flag(err),
        .drain_req(drain_req), .drain_ack(drain_ack),
        .arr_rst_req(arr_rst_req), .arr_rst_ack(arr_rst_ack),
        .restart_req(restart_req), .restart_ack(restart_ack),
        .log_req(log_req), .log_ack(log_ack),
        .shd_we(shd_we), .shd_idx(shd_idx), .shd_data(shd_data),
        .flt_en(flt_en), .flt_store(flt_store), .flt_idx(flt_idx), .flt_mask(flt_mask),
        .recovering(recovering), .chkstop(chkstop), .stop_cause(stop_cause)
    );

    // ---------------- reference model ----------------
    // phases: 0 RUN 1 FREEZE 2 DRAIN 3 ARRAY_RST 4 SCRUB 5 VERIFY 6 RESTART 7 CONFIRM 8 LOG 9 CHKSTOP
    int ph = 0, scan = 0, wc = 0, cause = 0;
    logic [31:0] tru [NREG];
    logic [CW-1:0] smask [NREG];

    function automatic int eff_pop(input int i);
        logic [CW-1:0] m;
        m = smask[i];
        if (flt_en && int'(flt_idx) == i) m = m ^ flt_mask;
        return $countones(m);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; scan = 0; wc = 0; cause = 0;
            for (int i = 0; i < NREG; i++) begin tru[i] = 0; smask[i] = 0; end
        end else begin
            bit ev, mt, bad, wr, stay;
            int nph, pc;
            ev  = a_v || b_v;
            mt  = a_v && b_v && a_i == b_i && a_d == b_d;
            bad = (ev && !mt) || err;
            wr  = 0;
            nph = ph;
            pc  = eff_pop(scan);
            case (ph)
                0: if (bad) nph = 1; else if (mt) wr = 1;
                1: nph = 2;
                2: if (drain_ack) nph = 3; else if (wc == TO-1) begin nph = 9; cause = 4; end
                3: if (arr_rst_ack) nph = 4; else if (wc == TO-1) begin nph = 9; cause = 4; end
                4: if (pc >= 2) begin nph = 9; cause = 1; end
                   else begin smask[scan] = 0; if (scan == NREG-1) nph = 5; end
                5: if (pc >= 1) begin nph = 9; cause = 2; end else if (scan == NREG-1) nph = 6;
                6: if (restart_ack) nph = 7; else if (wc == TO-1) begin nph = 9; cause = 4; end
                7: if (bad) begin nph = 9; cause = 3; end
                   else if (mt) begin wr = 1; nph = 8; end
                   else if (wc == TO-1) begin nph = 9; cause = 4; end
                8: if (bad) nph = 1;
                   else begin
                       if (mt) wr = 1;
                       if (log_ack) nph = 0; else if (wc == TO-1) begin nph = 9; cause = 4; end
                   end
                default: nph = 9;
            endcase
            if (wr) begin tru[a_i] = a_d; smask[a_i] = 0; end
            else if (flt_store) smask[flt_idx] = smask[flt_idx] ^ flt_mask;
            stay = (nph == ph);
            if ((ph == 4 || ph == 5) && stay) scan = scan + 1; else scan = 0;
            if ((ph == 2 || ph == 3 || ph == 6 || ph == 7 || ph == 8) && stay) wc = wc + 1; else wc = 0;
            ph = nph;
        end
    end

    // ---------------- checking ----------------
    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    function automatic string cause_tag(input int c);
        case (c)
            1: return "R7";
            2: return "R8";
            3: return "R9";
            4: return "R11";
            default: return "R1";
        endcase
    endfunction

    always begin
        @(negedge clk);
        #2;
        if (rst_n) begin
            bit xs;
            xs = (ph == 4) && (eff_pop(scan) < 2);
            check("R2", recovering, (ph >= 1 && ph <= 8));
            check("R12", chkstop, ph == 9);
            check(cause_tag(cause), stop_cause, cause);
            check("R5", drain_req, ph == 2);
            check("R5", arr_rst_req, ph == 3);
            check("R9", restart_req, ph == 6);
            check("R10", log_req, ph == 8);
            check("R6", shd_we, xs);
            if (xs && shd_we) begin
                check("R6", shd_idx, scan);
                check("R3", shd_data, tru[scan]);
                if (shd_idx == 5) seen5 = shd_data;
            end
        end
    end

    // ---------------- handshake responders ----------------
    always @(negedge clk) begin
        if (drain_req) begin drain_ack <= (drain_dly >= 0 && c_dr >= drain_dly); c_dr <= c_dr + 1; end
        else begin drain_ack <= 0; c_dr <= 0; end
        if (arr_rst_req) begin arr_rst_ack <= (arr_dly >= 0 && c_ar >= arr_dly); c_ar <= c_ar + 1; end
        else begin arr_rst_ack <= 0; c_ar <= 0; end
        if (restart_req) begin restart_ack <= (rst_dly >= 0 && c_rs >= rst_dly); c_rs <= c_rs + 1; end
        else begin restart_ack <= 0; c_rs <= 0; end
        if (log_req) begin log_ack <= (log_dly >= 0 && c_lg >= log_dly); c_lg <= c_lg + 1; end
        else begin log_ack <= 0; c_lg <= 0; end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic put(input logic av, input int ai, input logic [31:0] ad,
                       input logic bv, input int bi, input logic [31:0] bd, input logic e);
        @(negedge clk);
        a_v = av; a_i = IW'(ai); a_d = ad;
        b_v = bv; b_i = IW'(bi); b_d = bd; err = e;
        @(negedge clk);
        a_v = 0; b_v = 0; err = 0;
    endtask

    task automatic wr(input int i, input logic [31:0] d);
        put(1, i, d, 1, i, d, 0);
    endtask

    task automatic inject(input int i, input logic [CW-1:0] m);
        @(negedge clk);
        flt_store = 1; flt_idx = IW'(i); flt_mask = m;
        @(negedge clk);
        flt_store = 0; flt_mask = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; a_v = 0; b_v = 0; err = 0; flt_en = 0; flt_store = 0; flt_mask = 0;
        drain_dly = 3; arr_dly = 0; rst_dly = 2; log_dly = 4;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic to_confirm();
        do @(negedge clk); while (!restart_req);
        do @(negedge clk); while (restart_req);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        do_reset();
        #2;
        check("R1", {drain_req, arr_rst_req, restart_req, log_req, shd_we}, 0);
        check("R1", {recovering, chkstop, stop_cause}, 0);

        // normal commits, several patterns
        wr(0, 32'hA5A5_5A5A); wr(7, 32'hFFFF_FFFF); wr(3, 32'h0000_0001);
        wr(5, 32'h1234_5678); wr(6, 32'h8000_0000);
        inject(3, 39'h00_0000_0010);   // single data bit
        inject(6, 39'h08_0000_0000);   // single check bit
        // mismatch on data, then a matching result while frozen
        put(1, 2, 32'h1, 1, 2, 32'h2, 0);
        check("R2", recovering, 1);
        put(1, 5, 32'hDEAD_BEEF, 1, 5, 32'hDEAD_BEEF, 0);
        to_confirm();
        check("R4", seen5, 32'h1234_5678);
        wr(1, 32'hCAFE_0001);
        repeat (12) @(negedge clk);
        #2;
        check("R10", {recovering, chkstop}, 0);

        // external error flag, second full recovery with clean words
        wr(4, 32'h0F0F_0F0F);
        put(0, 0, 0, 0, 0, 0, 1);
        #2;
        check("R13", recovering, 1);
        to_confirm();
        put(1, 2, 32'h55AA_55AA, 1, 2, 32'h55AA_55AA, 0);
        repeat (12) @(negedge clk);
        #2;
        check("R10", recovering, 0);

        // persistent correctable fault seen again in the verify pass
        do_reset();
        wr(2, 32'h7777_0000);
        @(negedge clk); flt_en = 1; flt_idx = 2; flt_mask = 39'h00_0000_0100;
        put(0, 0, 0, 0, 0, 0, 1);
        repeat (40) @(negedge clk);
        #2;
        check("R8", {chkstop, stop_cause}, {1'b1, 3'd2});
        @(negedge clk); flt_en = 0; flt_mask = 0;

        // uncorrectable stored word during scrub
        do_reset();
        wr(4, 32'h0000_FFFF);
        inject(4, 39'h00_0000_0003);
        put(1, 1, 32'h0, 0, 1, 32'h0, 0);   // only one unit valid
        repeat (40) @(negedge clk);
        #2;
        check("R7", {chkstop, stop_cause}, {1'b1, 3'd1});

        // repeat error before first completion
        do_reset();
        put(0, 0, 0, 0, 0, 0, 1);
        to_confirm();
        put(1, 3, 32'h9, 1, 4, 32'h9, 0);   // index mismatch
        #2;
        check("R9", {chkstop, stop_cause}, {1'b1, 3'd3});

        // handshake that is never acknowledged
        do_reset();
        drain_dly = -1;
        put(0, 0, 0, 0, 0, 0, 1);
        repeat (45) @(negedge clk);
        #2;
        check("R11", {chkstop, stop_cause}, {1'b1, 3'd4});
        drain_dly = 0;
        wr(1, 32'h1);
        put(0, 0, 0, 0, 0, 0, 1);
        repeat (5) @(negedge clk);
        #2;
        check("R12", {chkstop, stop_cause, drain_req, shd_we}, {1'b1, 3'd4, 1'b0, 1'b0});

        do_reset();
        #2;
        check("R12", chkstop, 0);
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule